// File: doc/BRIEF.md
# Address Protection and Relocation Unit

This unit sits on the path from a processor's address output to memory. Each request carries an address, a privilege bit and a scheme select. The unit either passes the address through, or relocates it, or refuses it with a trap. There are three schemes:

- **Fence.** A single boundary register keeps user code out of the kernel region, which lies below the boundary.
- **Static bounds.** A lower and an upper register bracket the region the process may touch.
- **Dynamic relocation.** A base register is added to the address, and a limit register caps the offset.

The kernel reloads the five boundary registers through a write port on every context switch.

The response is registered. It is produced by a three-state sequencer:

- `ST_IDLE` means no request was presented in the previous cycle.
- `ST_GRANT` means the previous request was accepted, and the memory strobe is raised with the final address.
- `ST_TRAP` means the previous request was refused, the strobe stays low and the trap flag is raised.

From any state the sequencer moves as follows:

- To `ST_GRANT` on a valid request that passes its check.
- To `ST_TRAP` on a valid request that fails its check.
- To `ST_IDLE` when no request is present.

Top module: `addr_guard_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after release with no request, `mem_valid` and `trap` are both 0. All five boundary registers reset to zero.
- R2: The outcome of a request presented in cycle N appears in cycle N+1. Exactly one of `mem_valid` or `trap` is 1 after a request, and neither is 1 after a cycle without one. They are never both 1.
- R3: Scheme code 0 (fence) traps a user request whose address is below the fence register. Any other user request is granted with `mem_addr` equal to the request address.
- R4: Scheme code 1 (bounds) traps a user request whose address is below the lower register, or equal to or above the upper register. Any other user request is granted with the address unchanged.
- R5: Scheme code 2 (relocation) traps a user request whose address is equal to or above the limit register.
- R6: Scheme code 2 grants a user request within the limit with `mem_addr` equal to base plus the request address, taken modulo 2^AW.
- R7: Under scheme code 2, a user request for which base plus address carries out of AW bits traps, even when the address is within the limit.
- R8: A kernel request (`req_user`=0) is granted with the address unchanged under every scheme code.
- R9: A register write takes effect from the next cycle. A request in the same cycle as the write is judged against the old value.
- R10: Scheme code 3 traps every user request.
- R11: Writes with `cfg_sel` of 0 to 4 load fence, lower, upper, base and limit respectively. Codes 5 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Processor-generated address |
| req_user | input | 1 | 1 = user privilege, 0 = kernel |
| req_scheme | input | 2 | 0 fence, 1 bounds, 2 relocation, 3 lock out user |
| cfg_we | input | 1 | Boundary register write enable |
| cfg_sel | input | 3 | Register select for the write |
| cfg_wdata | input | AW | Write data |
| mem_valid | output | 1 | Granted access strobe |
| mem_addr | output | AW | Final memory address, valid with `mem_valid` |
| trap | output | 1 | Request refused |

## Verification
A corrupted boundary register shows up on the next user request judged against it. That request either traps where a grant was due or is granted where a trap was due, so the fault is visible one cycle after that request. A wrong sequencer state shows at once as a strobe or trap with no request behind it, or as both flags together. A wrong relocation sum shows as a `mem_addr` mismatch in the grant cycle. The stimulus walks each scheme across both sides of every boundary, including the exact equal value, so an off-by-one compare is caught at the first edge probe.

// File: rtl/addr_guard_pkg.sv
package addr_guard_pkg;

    // Scheme select codes.
    typedef enum logic [1:0] {
        SCH_FENCE  = 2'd0,
        SCH_BOUNDS = 2'd1,
        SCH_RELOC  = 2'd2,
        SCH_LOCK   = 2'd3
    } scheme_e;

    // Response sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_TRAP  = 2'd2
    } state_e;

    // Boundary register select codes.
    localparam int unsigned CSEL_W     = 3;
    localparam int unsigned NREG       = 5;
    localparam logic [2:0]  CSEL_FENCE = 3'd0;
    localparam logic [2:0]  CSEL_LOWER = 3'd1;
    localparam logic [2:0]  CSEL_UPPER = 3'd2;
    localparam logic [2:0]  CSEL_BASE  = 3'd3;
    localparam logic [2:0]  CSEL_LIMIT = 3'd4;

endpackage

// File: rtl/addr_guard_regs.sv
module addr_guard_regs
    import addr_guard_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CSEL_W-1:0] sel,
    input  logic [AW-1:0]     wdata,
    output logic [AW-1:0]     fence,
    output logic [AW-1:0]     lower,
    output logic [AW-1:0]     upper,
    output logic [AW-1:0]     base,
    output logic [AW-1:0]     limit
);

    logic [AW-1:0] bank [NREG];

    // One flop bank per select code. Codes without a bank are dropped.
    for (genvar g = 0; g < NREG; g++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank[g] <= '0;
            end else if (we && (sel == CSEL_W'(g))) begin
                bank[g] <= wdata;
            end
        end
    end

    assign fence = bank[CSEL_FENCE];
    assign lower = bank[CSEL_LOWER];
    assign upper = bank[CSEL_UPPER];
    assign base  = bank[CSEL_BASE];
    assign limit = bank[CSEL_LIMIT];

endmodule

// File: rtl/addr_guard_check.sv
module addr_guard_check
    import addr_guard_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic          user,
    input  logic [1:0]    scheme,
    input  logic [AW-1:0] fence,
    input  logic [AW-1:0] lower,
    input  logic [AW-1:0] upper,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic          refuse,
    output logic [AW-1:0] out_addr
);

    localparam int unsigned SW = AW + 1;

    logic [SW-1:0] sum;
    logic          below_fence;
    logic          out_of_bounds;
    logic          over_limit;
    logic          carry_out;

    assign sum           = {1'b0, base} + {1'b0, addr};
    assign carry_out     = sum[AW];
    assign below_fence   = addr < fence;
    assign out_of_bounds = (addr < lower) || (addr >= upper);
    assign over_limit    = addr >= limit;

    always_comb begin
        refuse   = 1'b0;
        out_addr = addr;
        if (user) begin
            unique case (scheme_e'(scheme))
                SCH_FENCE:  refuse = below_fence;
                SCH_BOUNDS: refuse = out_of_bounds;
                SCH_RELOC: begin
                    refuse   = over_limit || carry_out;
                    out_addr = sum[AW-1:0];
                end
                SCH_LOCK:   refuse = 1'b1;
                default:    refuse = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/addr_guard_seq.sv
module addr_guard_seq
    import addr_guard_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          refuse,
    input  logic [AW-1:0] next_addr,
    output logic          mem_valid,
    output logic          trap,
    output logic [AW-1:0] mem_addr
);

    state_e        state_q;
    state_e        state_d;
    logic [AW-1:0] addr_q;

    // Next state.
    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            state_d = refuse ? ST_TRAP : ST_GRANT;
        end
    end

    // State and address registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                addr_q <= next_addr;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        mem_valid = 1'b0;
        trap      = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_GRANT: mem_valid = 1'b1;
            ST_TRAP:  trap = 1'b1;
            default:  ;
        endcase
    end

    assign mem_addr = addr_q;

endmodule

// File: rtl/addr_guard_unit.sv
module addr_guard_unit
    import addr_guard_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_user,
    input  logic [1:0]        req_scheme,
    input  logic              cfg_we,
    input  logic [CSEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]     cfg_wdata,
    output logic              mem_valid,
    output logic [AW-1:0]     mem_addr,
    output logic              trap
);

    logic [AW-1:0] r_fence;
    logic [AW-1:0] r_lower;
    logic [AW-1:0] r_upper;
    logic [AW-1:0] r_base;
    logic [AW-1:0] r_limit;
    logic          refuse;
    logic [AW-1:0] next_addr;

    addr_guard_regs #(.AW(AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .fence (r_fence),
        .lower (r_lower),
        .upper (r_upper),
        .base  (r_base),
        .limit (r_limit)
    );

    addr_guard_check #(.AW(AW)) u_check (
        .addr     (req_addr),
        .user     (req_user),
        .scheme   (req_scheme),
        .fence    (r_fence),
        .lower    (r_lower),
        .upper    (r_upper),
        .base     (r_base),
        .limit    (r_limit),
        .refuse   (refuse),
        .out_addr (next_addr)
    );

    addr_guard_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .refuse    (refuse),
        .next_addr (next_addr),
        .mem_valid (mem_valid),
        .trap      (trap),
        .mem_addr  (mem_addr)
    );

endmodule

// File: rtl/addr_guard_props.sv
module addr_guard_props #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          req_user,
    input logic [1:0]    req_scheme,
    input logic          mem_valid,
    input logic [AW-1:0] mem_addr,
    input logic          trap
);

    // R2
    exclusive_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid && trap));

    // R2
    answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (mem_valid || trap));

    // R2
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!mem_valid && !trap));

    // R8
    kernel_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_user) |=> (mem_valid && mem_addr == $past(req_addr)));

    // R3
    fence_unchanged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_scheme == 2'd0) |=> (trap || mem_addr == $past(req_addr)));

    // R4
    bounds_unchanged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_scheme == 2'd1) |=> (trap || mem_addr == $past(req_addr)));

    // R10
    lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user && req_scheme == 2'd3) |=> trap);

endmodule

bind addr_guard_unit addr_guard_props #(.AW(AW)) u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_user   (req_user),
    .req_scheme (req_scheme),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .trap       (trap)
);

// File: tb/tb_addr_guard_unit.sv
module tb_addr_guard_unit;

    localparam int unsigned AW       = 32;
    localparam time         CLK_PER  = 10ns;
    localparam int unsigned WATCHDOG = 5000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          req_user;
    logic [1:0]    req_scheme;
    logic          cfg_we;
    logic [2:0]    cfg_sel;
    logic [AW-1:0] cfg_wdata;
    logic          mem_valid;
    logic [AW-1:0] mem_addr;
    logic          trap;

    typedef struct {
        logic          ev;
        logic          et;
        logic [AW-1:0] ea;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp  = 0;
    int   n_bad  = 0;
    bit   done   = 1'b0;

    // Bench model of the five boundary registers.
    logic [AW-1:0] m_fence, m_lower, m_upper, m_base, m_limit;

    always #(CLK_PER/2) clk = ~clk;

    addr_guard_unit #(.AW(AW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_user   (req_user),
        .req_scheme (req_scheme),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .mem_valid  (mem_valid),
        .mem_addr   (mem_addr),
        .trap       (trap)
    );

    // Monitor: compares each item a quarter period after the edge.
    always @(posedge clk) begin
        #(CLK_PER/4);
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (mem_valid !== e.ev || trap !== e.et ||
                (e.ev && mem_addr !== e.ea)) begin
                n_bad++;
                $display("FAIL %s: got valid=%0b trap=%0b addr=%h, expected valid=%0b trap=%0b addr=%h",
                         e.tag, mem_valid, trap, mem_addr, e.ev, e.et, e.ea);
            end
        end
    end

    // Expected outcome derived from R3..R10.
    function automatic exp_t predict(logic [AW-1:0] a, logic u, logic [1:0] s, string tag);
        exp_t          e;
        logic [AW:0]   sum;
        e.ev  = 1'b1;
        e.et  = 1'b0;
        e.ea  = a;
        e.tag = tag;
        if (u) begin
            case (s)
                2'd0: e.et = (a < m_fence);
                2'd1: e.et = (a < m_lower) || (a >= m_upper);
                2'd2: begin
                    sum  = {1'b0, m_base} + {1'b0, a};
                    e.et = (a >= m_limit) || sum[AW];
                    e.ea = sum[AW-1:0];
                end
                default: e.et = 1'b1;
            endcase
        end
        if (e.et) e.ev = 1'b0;
        return e;
    endfunction

    task automatic model_write(logic [2:0] s, logic [AW-1:0] d);
        case (s)
            3'd0: m_fence = d;
            3'd1: m_lower = d;
            3'd2: m_upper = d;
            3'd3: m_base  = d;
            3'd4: m_limit = d;
            default: ;
        endcase
    endtask

    // Driver: one cycle, optional request, optional write.
    task automatic cycle(bit rv, logic [AW-1:0] a, logic u, logic [1:0] s,
                         bit we, logic [2:0] ws, logic [AW-1:0] wd, string tag);
        exp_t e;
        @(negedge clk);
        req_valid  = rv;
        req_addr   = a;
        req_user   = u;
        req_scheme = s;
        cfg_we     = we;
        cfg_sel    = ws;
        cfg_wdata  = wd;
        if (rv) begin
            e = predict(a, u, s, tag);
        end else begin
            e.ev = 1'b0; e.et = 1'b0; e.ea = '0; e.tag = tag;
        end
        q.push_back(e);
        if (we) model_write(ws, wd);
    endtask

    task automatic req(logic [AW-1:0] a, logic u, logic [1:0] s, string tag);
        cycle(1'b1, a, u, s, 1'b0, 3'd0, '0, tag);
    endtask

    task automatic wr(logic [2:0] ws, logic [AW-1:0] wd);
        cycle(1'b0, '0, 1'b0, 2'd0, 1'b1, ws, wd, "R2");
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_fence = '0; m_lower = '0; m_upper = '0; m_base = '0; m_limit = '0;
        rst_n = 1'b0; req_valid = 0; req_addr = '0; req_user = 0; req_scheme = 0;
        cfg_we = 0; cfg_sel = 0; cfg_wdata = '0;
        repeat (3) @(posedge clk);
        #(CLK_PER/4);
        n_cmp++;
        if (mem_valid !== 1'b0 || trap !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: in reset got valid=%0b trap=%0b, expected 0 0", mem_valid, trap);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset, zeroed registers
        cycle(1'b0, '0, 1'b0, 2'd0, 1'b0, 3'd0, '0, "R1");
        req(32'h0000_0040, 1'b1, 2'd1, "R1");
        req(32'h0000_0040, 1'b1, 2'd2, "R1");
        req(32'h0000_0040, 1'b1, 2'd0, "R1");

        // R3 fence
        wr(3'd0, 32'h0001_0000);
        req(32'h0000_FFFF, 1'b1, 2'd0, "R3");
        req(32'h0001_0000, 1'b1, 2'd0, "R3");
        req(32'h8000_1234, 1'b1, 2'd0, "R3");
        req(32'h0000_0000, 1'b1, 2'd0, "R3");

        // R11 loads via codes 1..4, then codes 5..7 ignored
        wr(3'd1, 32'h0000_2000);
        wr(3'd2, 32'h0000_3000);
        wr(3'd3, 32'h0040_0000);
        wr(3'd4, 32'h0000_1000);
        wr(3'd5, 32'h0000_0000);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'h0000_0001);
        req(32'h0000_2000, 1'b1, 2'd1, "R11");
        req(32'h0000_0FFF, 1'b1, 2'd2, "R11");
        req(32'h0000_8000, 1'b1, 2'd0, "R11");

        // R4 bounds edges
        req(32'h0000_1FFF, 1'b1, 2'd1, "R4");
        req(32'h0000_2000, 1'b1, 2'd1, "R4");
        req(32'h0000_2FFF, 1'b1, 2'd1, "R4");
        req(32'h0000_3000, 1'b1, 2'd1, "R4");

        // R5 / R6 relocation
        req(32'h0000_0000, 1'b1, 2'd2, "R6");
        req(32'h0000_0ABC, 1'b1, 2'd2, "R6");
        req(32'h0000_0FFF, 1'b1, 2'd2, "R5");
        req(32'h0000_1000, 1'b1, 2'd2, "R5");
        req(32'h0000_7000, 1'b1, 2'd2, "R5");

        // R7 overflow of base plus address
        wr(3'd3, 32'hFFFF_F000);
        wr(3'd4, 32'h0000_2000);
        req(32'h0000_0FFF, 1'b1, 2'd2, "R7");
        req(32'h0000_1000, 1'b1, 2'd2, "R7");
        req(32'h0000_1FFF, 1'b1, 2'd2, "R7");

        // R8 kernel bypass in every scheme
        for (int s = 0; s < 4; s++) begin
            req(32'h0000_0010 + AW'(s), 1'b0, 2'(s), "R8");
        end
        req(32'h0000_1800, 1'b0, 2'd2, "R8");

        // R10 lock-out code
        req(32'h0000_0000, 1'b1, 2'd3, "R10");
        req(32'h0001_8000, 1'b1, 2'd3, "R10");

        // R9 write and request in the same cycle
        cycle(1'b1, 32'h0000_0500, 1'b1, 2'd0, 1'b1, 3'd0, 32'h0000_0400, "R9");
        req(32'h0000_0500, 1'b1, 2'd0, "R9");
        cycle(1'b1, 32'h0000_0500, 1'b1, 2'd0, 1'b1, 3'd0, 32'h0000_0600, "R9");
        req(32'h0000_0500, 1'b1, 2'd0, "R9");

        // R2 back-to-back mix then idle
        req(32'h0000_0700, 1'b1, 2'd0, "R2");
        req(32'h0000_0100, 1'b1, 2'd0, "R2");
        cycle(1'b0, '0, 1'b0, 2'd0, 1'b0, 3'd0, '0, "R2");
        cycle(1'b0, '0, 1'b0, 2'd0, 1'b0, 3'd0, '0, "R2");

        repeat (2) @(posedge clk);
        #(CLK_PER/2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule